// File: doc/BRIEF.md
# Privilege-Checked Application Register File

This block holds the application-visible special registers of a processor core: a small bank of kernel-to-application message registers, the register-stack configuration word, the two backing-store address pointers, the two NaT collection words, the compare value used by compare-and-exchange, and the epilog counter used by modulo-scheduled loops. The registers sit in a 128-entry index space. Some stretches of that space are held back for future compatible extension. The rest is reserved outright.

The execute stage sends at most one request per cycle. A request carries a read/write flag, a 7-bit index, 64 bits of write data and the current privilege level, where 0 is the most privileged. One cycle later the block returns the read data and a fault code. The rules depend on the index and on the privilege level:

- Some registers refuse writes.
- Some registers have bits that are fixed at zero.
- The stack-configuration privilege field is clamped so that software cannot lift it above its own level.
- Ignored and reserved indices behave differently from each other.

A faulting access changes no state.

Top module: `appreg_file`

## Requirements
- R1: After reset every register reads as zero and `rsp_valid` is low.
- R2: Each accepted request (`req_valid` high at a rising edge) produces `rsp_valid` high for exactly the next cycle. Read data shows the register contents as they were before that request.
- R3: Indices 0 to 7 are kernel registers. A read succeeds at any privilege level. A write succeeds only at privilege 0. A write at any other level returns fault code 1 and leaves the register unchanged.
- R4: Index 16 is the stack configuration word. It stores only bits 1:0 (mode), 3:2 (privilege field), 4 (byte order) and 29:16 (load distance). Every other bit reads as zero.
- R5: On a write to index 16, if the written privilege field is numerically below the requester's privilege level, the field stores the requester's level instead.
- R6: Index 17 is read-only from the request port. A write to it returns fault code 2 and changes nothing. A successful write to index 18 loads bits 63:3 of the written data into both index 17 and index 18, with bits 2:0 cleared.
- R7: Bits 2:0 of indices 17 and 18 always read as zero.
- R8: Bit 63 of index 19 always reads as zero, whatever was written.
- R9: Index 66 keeps only its low 6 bits. Bits 63:6 read as zero.
- R10: Indices 32 and 36 store and return all 64 bits.
- R11: Indices 48 to 63 and 112 to 127 are ignored. A read of one returns zero with fault code 0. A write to one returns fault code 0 and changes no register.
- R12: Every other index is reserved. Any access to a reserved index returns fault code 2, returns zero data and changes no register.
- R13: Fault codes are 0 (none), 1 (privileged register) and 2 (illegal operation). Read data is zero on every write and on every faulting access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 7 | Register index |
| req_wdata | input | 64 | Write data |
| req_pl | input | 2 | Current privilege level, 0 = most privileged |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_fault | output | 2 | Fault code |

## Verification
The bench builds the block with its default parameters: eight kernel registers and a 6-bit epilog counter. At these values the whole index map applies, including the kernel range at 0 to 7, so every reserved gap, both ignored windows and the privilege rule on the kernel range are all reachable. Random requests are biased toward the implemented and boundary indices (7, 8, 47, 48, 63, 64, 111, 112) and use all four privilege levels. Together with the random write data, this reaches the clamp on the stack privilege field, the masked pointer bits and bit 63 of the NaT word many times over.

// File: rtl/appreg_file.sv
module appreg_file #(
  parameter int KR_COUNT = 8,
  parameter int EC_BITS  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [6:0]  req_index,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  req_pl,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic [1:0]  rsp_fault
);

  localparam logic [6:0]  KR_LIM   = 7'(KR_COUNT);
  localparam logic [63:0] RSC_MASK = 64'h0000_0000_3FFF_001F;
  localparam logic [63:0] EC_MASK  = {{(64 - EC_BITS){1'b0}}, {EC_BITS{1'b1}}};
  localparam logic [1:0]  F_NONE = 2'd0, F_PRIV = 2'd1, F_ILL = 2'd2;

  logic [63:0] kr_q [KR_COUNT];
  logic [63:0] rsc_q, bsp_q, bspst_q, rnat_q, ccv_q, unat_q, ec_q;

  logic        is_kr, is_ign, known;
  logic [1:0]  fault_c;
  logic [63:0] rd_c, kr_rd;
  logic        we;
  logic [1:0]  pl_new;

  assign is_kr  = req_index < KR_LIM;
  assign is_ign = (req_index[6:4] == 3'b011) || (req_index[6:4] == 3'b111);
  assign known  = is_kr || req_index inside {7'd16, 7'd17, 7'd18, 7'd19, 7'd32, 7'd36, 7'd66};

  always_comb begin
    kr_rd = '0;
    for (int k = 0; k < KR_COUNT; k++)
      if (req_index == 7'(k)) kr_rd = kr_q[k];
  end

  always_comb begin
    fault_c = F_NONE;
    if (is_ign)                           fault_c = F_NONE;
    else if (!known)                      fault_c = F_ILL;
    else if (req_write && is_kr && req_pl != 2'd0) fault_c = F_PRIV;
    else if (req_write && req_index == 7'd17)      fault_c = F_ILL;
  end

  always_comb begin
    rd_c = '0;
    if (is_kr) rd_c = kr_rd;
    else case (req_index)
      7'd16:   rd_c = rsc_q;
      7'd17:   rd_c = bsp_q;
      7'd18:   rd_c = bspst_q;
      7'd19:   rd_c = rnat_q;
      7'd32:   rd_c = ccv_q;
      7'd36:   rd_c = unat_q;
      7'd66:   rd_c = ec_q;
      default: rd_c = '0;
    endcase
    if (req_write || fault_c != F_NONE || is_ign) rd_c = '0;
  end

  assign we     = req_valid && req_write && known && !is_ign && fault_c == F_NONE;
  assign pl_new = (req_wdata[3:2] < req_pl) ? req_pl : req_wdata[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < KR_COUNT; k++) kr_q[k] <= '0;
      rsc_q <= '0; bsp_q <= '0; bspst_q <= '0; rnat_q <= '0;
      ccv_q <= '0; unat_q <= '0; ec_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_fault <= F_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_c : '0;
      rsp_fault <= req_valid ? fault_c : F_NONE;
      if (we) begin
        for (int k = 0; k < KR_COUNT; k++)
          if (req_index == 7'(k)) kr_q[k] <= req_wdata;
        case (req_index)
          7'd16: rsc_q <= {req_wdata[63:4] & RSC_MASK[63:4], pl_new, req_wdata[1:0]};
          7'd18: begin
            bspst_q <= {req_wdata[63:3], 3'b000};
            bsp_q   <= {req_wdata[63:3], 3'b000};
          end
          7'd19: rnat_q <= {1'b0, req_wdata[62:0]};
          7'd32: ccv_q  <= req_wdata;
          7'd36: unat_q <= req_wdata;
          7'd66: ec_q   <= req_wdata & EC_MASK;
          default: ;
        endcase
      end
    end
  end

  a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_kr_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_index < KR_LIM && req_pl != 2'd0) |=> rsp_fault == F_PRIV);
  a_r5_rsc_pl_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_index == 7'd16) |=> rsc_q[3:2] >= $past(req_pl));
  a_r7_bsp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_index == 7'd17 || req_index == 7'd18)) |=> rsp_rdata[2:0] == 3'b000);
  a_r8_rnat_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rnat_q[63] == 1'b0);
  a_r11_ignored_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_index[6:4] == 3'b011 || req_index[6:4] == 3'b111)) |=> (rsp_fault == F_NONE && rsp_rdata == '0));
  a_r13_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != F_NONE) |-> rsp_rdata == '0);

endmodule

// File: tb/sim_appreg_file.sv
`timescale 1ns/1ps
module sim_appreg_file;
  localparam int KRN = 8;
  localparam logic [63:0] RSCM = 64'h0000_0000_3FFF_001F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_index = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0] req_pl = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;
  logic [1:0] rsp_fault;

  int n_cmp = 0, n_bad = 0;
  logic [63:0] mdl [128];

  always #4 clk = ~clk;

  appreg_file #(.KR_COUNT(KRN), .EC_BITS(6)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .req_pl(req_pl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault));

  function automatic bit f_ign(logic [6:0] i);
    return (i >= 7'd48 && i <= 7'd63) || i >= 7'd112;
  endfunction
  function automatic bit f_known(logic [6:0] i);
    return i < 7'(KRN) || i == 16 || i == 17 || i == 18 || i == 19 || i == 32 || i == 36 || i == 66;
  endfunction
  function automatic logic [1:0] f_fault(logic w, logic [6:0] i, logic [1:0] pl);
    if (f_ign(i)) return 2'd0;
    if (!f_known(i)) return 2'd2;
    if (w && i < 7'(KRN) && pl != 0) return 2'd1;
    if (w && i == 17) return 2'd2;
    return 2'd0;
  endfunction
  function automatic string f_tag(logic w, logic [6:0] i);
    if (f_ign(i)) return "R11";
    if (!f_known(i)) return "R12";
    if (i < 7'(KRN)) return "R3";
    case (i)
      16: return w ? "R5" : "R4";
      17: return "R6";
      18: return "R7";
      19: return "R8";
      66: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, after checking.
  task automatic issue(logic w, logic [6:0] i, logic [63:0] d, logic [1:0] pl);
    logic [1:0] ef;
    logic [63:0] ed, m;
    string t;
    req_valid = 1'b1; req_write = w; req_index = i; req_wdata = d; req_pl = pl;
    ef = f_fault(w, i, pl);
    t = f_tag(w, i);
    ed = (w || ef != 0 || f_ign(i)) ? 64'd0 : mdl[i];
    if (w && ef == 0 && f_known(i) && !f_ign(i)) begin
      if (i < 7'(KRN)) mdl[i] = d;
      else case (i)
        16: begin m = d & RSCM; if (d[3:2] < pl) m[3:2] = pl; mdl[16] = m; end
        18: begin mdl[18] = {d[63:3], 3'b000}; mdl[17] = mdl[18]; end
        19: mdl[19] = {1'b0, d[62:0]};
        66: mdl[66] = d & 64'h3F;
        default: mdl[i] = d;
      endcase
    end
    @(negedge clk);
    check({"R2 valid ", t}, {63'd0, rsp_valid}, 64'd1);
    check({"R13 fault ", t}, {62'd0, rsp_fault}, {62'd0, ef});
    check({"R13 data ", t}, rsp_rdata, ed);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 idle valid", {63'd0, rsp_valid}, 64'd0);
  endtask

  logic [6:0] picks [20] = '{7'd0, 7'd3, 7'd7, 7'd8, 7'd16, 7'd17, 7'd18, 7'd19, 7'd32, 7'd36,
                             7'd66, 7'd47, 7'd48, 7'd63, 7'd64, 7'd111, 7'd112, 7'd127, 7'd20, 7'd5};

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 128; k++) mdl[k] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything reads zero after reset
    foreach (picks[k]) issue(1'b0, picks[k], 64'd0, 2'd3);
    // R3: kernel write at privilege 2 faults; at 0 it sticks
    issue(1'b1, 7'd4, 64'hDEAD_BEEF_0123_4567, 2'd2);
    issue(1'b0, 7'd4, 64'd0, 2'd3);
    issue(1'b1, 7'd4, 64'hDEAD_BEEF_0123_4567, 2'd0);
    issue(1'b0, 7'd4, 64'd0, 2'd3);
    // R4 and R5: all-ones at privilege 2 stores the masked word with field 2
    issue(1'b1, 7'd16, 64'hFFFF_FFFF_FFFF_FFF3, 2'd2);
    issue(1'b0, 7'd16, 64'd0, 2'd0);
    check("R5 clamped rsc", mdl[16], 64'h0000_0000_3FFF_001B);
    // R6 and R7: writing 17 faults; writing 18 fills both pointers
    issue(1'b1, 7'd18, 64'h1234_5678_9ABC_DEFF, 2'd3);
    issue(1'b1, 7'd17, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
    issue(1'b0, 7'd17, 64'd0, 2'd1);
    issue(1'b0, 7'd18, 64'd0, 2'd1);
    // R8, R9, R10
    issue(1'b1, 7'd19, '1, 2'd3);  issue(1'b0, 7'd19, 64'd0, 2'd3);
    issue(1'b1, 7'd66, '1, 2'd3);  issue(1'b0, 7'd66, 64'd0, 2'd3);
    issue(1'b1, 7'd32, '1, 2'd3);  issue(1'b0, 7'd32, 64'd0, 2'd3);
    // R11: ignored write leaves every readable register as it was
    issue(1'b1, 7'd50, '1, 2'd0);
    issue(1'b0, 7'd50, 64'd0, 2'd0);
    // R12: reserved write faults and changes nothing
    issue(1'b1, 7'd20, '1, 2'd0);
    foreach (picks[k]) issue(1'b0, picks[k], 64'd0, 2'd0);
    idle();
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] ix;
      ix = ($urandom % 4 == 0) ? 7'($urandom) : picks[$urandom % 20];
      issue(1'($urandom), ix, {$urandom, $urandom}, 2'($urandom));
      if ($urandom % 50 == 0) idle();
    end
    foreach (picks[k]) issue(1'b0, picks[k], 64'd0, 2'd0);
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule